// File: doc/BRIEF.md
# SPI Flash Command Cycle Engine

A host-programmed engine that runs one SPI flash command cycle at a time. The host loads an eight-entry table of command opcodes, a 16-bit word giving each table entry a two-bit cycle kind, a prefix opcode, a 24-bit flash address and a 64-byte data buffer. A write to the control register with the go bit set picks a table entry by index and launches the cycle. The engine can first send the prefix opcode (typically write enable) in a frame of its own. It then sends the chosen opcode, the address when the kind calls for one, and an optional data phase of 1 to 64 bytes that either sends bytes from the buffer or captures bytes into it.

The SPI side uses mode 0: the clock idles low, MOSI changes on falling edges and MISO is sampled on rising edges. Two clock rates are available, slow and fast, each set by a half-period parameter counted in system clocks. A sticky lock bit freezes the opcode table, the kind word and the prefix register until reset. Progress and outcome appear as status bits: busy, done and error. Done and error stay set until the host writes ones to them.

Register map (word index on `host_waddr`/`host_raddr`): 0 control, 1 status, 2 flash address, 3 kind word, 4 prefix opcode, 5 table entries 0..3 (entry 0 in bits [7:0]), 6 table entries 4..7, 7 lock. Index 16+w is buffer word w, with buffer byte 4w in bits [7:0].

Top module: `spi_cycle_engine`

## Requirements
- R1: After synchronous reset the status word reads 0, `spi_cs_n` is 1 and `spi_sclk` is 0.
- R2: SPI mode 0. `spi_sclk` is low whenever chip select is high. MOSI is sampled on the rising edge, MSB first.
- R3: A control write with bit 0 set starts a cycle while the engine is idle. Bits [6:4] pick table entry i. The opcode sent is that entry. The entry's kind is bits [2i+1:2i] of the kind word: 0 read without address, 1 write without address, 2 read with address, 3 write with address.
- R4: For kinds 2 and 3 the opcode is followed by address bits [23:0] as three bytes, most significant first. Address bits [31:24] are ignored.
- R5: Control bit 2 enables a data phase of (bits [13:8] + 1) bytes. Write kinds send buffer bytes from byte 0 upward. Read kinds send 0x00 and store the received bytes into the buffer from byte 0 upward. Buffer bytes beyond the count keep their values.
- R6: Control bit 1 sends the prefix register as a one-byte frame first. Chip select then stays high for at least 2 SPI clock periods before the main frame, and no other frame comes between them.
- R7: Status bit 0 is busy during a cycle. Bit 1 (done) is set when the cycle ends. Bits 1 and 2 clear when the host writes 1 to them. A set in the same cycle as a clear wins.
- R8: A go write during a busy cycle starts nothing. Status bit 2 (error) is set when the running cycle ends.
- R9: Control bit 15 selects the fast SPI clock (period 2*DIV_FAST system clocks). Otherwise the period is 2*DIV_SLOW.
- R10: Writing 1 to bit 0 of the lock register sets the lock until reset. While it is set, writes to the opcode table, kind word and prefix register are ignored. Other registers stay writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_waddr | input | 5 | Host write word index |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | 5 | Host read word index |
| host_rdata | output | 32 | Registered read data, one cycle after the index |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
At the end of a cycle, the engine setting the done and error bits can fall in the same system clock as a host write-one-to-clear on the status register. The bench holds a clearing write asserted on every clock of a running cycle. It releases the write only after the registered status read shows busy low, which places the last clearing write in exactly the clock where done is set. Done must then still read as 1. A go write issued into a busy cycle also checks that the cycle's end and the error report coincide, with only one frame on the wire.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int MENU_N = 8;

  typedef enum logic [1:0] {
    K_RD     = 2'd0,
    K_WR     = 2'd1,
    K_RD_ADR = 2'd2,
    K_WR_ADR = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    RG_CTRL    = 3'd0,
    RG_STAT    = 3'd1,
    RG_ADDR    = 3'd2,
    RG_TYPES   = 3'd3,
    RG_PREFIX  = 3'd4,
    RG_MENU_LO = 3'd5,
    RG_MENU_HI = 3'd6,
    RG_LOCK    = 3'd7
  } reg_e;

  localparam int CTL_GO     = 0;
  localparam int CTL_ATOMIC = 1;
  localparam int CTL_DATA   = 2;
  localparam int CTL_IDX    = 4;
  localparam int CTL_CNT    = 8;
  localparam int CTL_FAST   = 15;

  localparam int ST_BUSY = 0;
  localparam int ST_DONE = 1;
  localparam int ST_ERR  = 2;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [7:0]       tx,
  input  logic [DIV_W-1:0] half,
  input  logic             miso,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rx,
  output logic             sclk,
  output logic             mosi
);
  logic [DIV_W-1:0] cnt;
  logic [2:0]       bitn;
  logic [7:0]       sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; rx <= '0; sclk <= 1'b0; mosi <= 1'b0;
      cnt <= '0; bitn <= '0; sh <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; sh <= tx; mosi <= tx[7]; cnt <= '0; bitn <= '0;
        end
      end else if (cnt == half - 1'b1) begin
        cnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == 3'd7) begin
            busy <= 1'b0; done <= 1'b1;
          end else begin
            bitn <= bitn + 3'd1;
            sh   <= {sh[6:0], 1'b0};
            mosi <= sh[6];
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_SCLK_LOW_AT_REST: assert property (@(posedge clk) disable iff (rst) !busy |-> !sclk); // R2
endmodule

// File: rtl/spi_cycle_seq.sv
module spi_cycle_seq
  import spi_eng_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int GAP_SPI   = 2,
  parameter int DIV_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  kind_e            kind,
  input  logic             atomic,
  input  logic             data_en,
  input  logic [$clog2(BUF_BYTES)-1:0] last,
  input  logic [23:0]      addr,
  input  logic [7:0]       prefix,
  input  logic [DIV_W-1:0] half,
  input  logic [7:0]       buf_rd,
  input  logic             sh_done,
  input  logic [7:0]       sh_rx,
  output logic             busy,
  output logic             cyc_done,
  output logic             cs_n,
  output logic             sh_start,
  output logic [7:0]       sh_tx,
  output logic [$clog2(BUF_BYTES)-1:0] buf_idx,
  output logic             buf_we,
  output logic [$clog2(BUF_BYTES)-1:0] buf_widx,
  output logic [7:0]       buf_wdata
);
  localparam int CW = $clog2(BUF_BYTES);
  localparam int GW = DIV_W + $clog2(2 * GAP_SPI) + 1;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_GAP, S_CMD, S_ADDR, S_DLOAD, S_DATA} st_e;
  st_e st;

  logic [7:0]    op_q;
  kind_e         kind_q;
  logic          de_q;
  logic [CW-1:0] last_q;
  logic [23:0]   addr_q;
  logic [1:0]    abyte;
  logic [GW-1:0] gap_cnt, gap_len;

  wire is_write = (kind_q == K_WR) || (kind_q == K_WR_ADR);
  wire has_addr = (kind_q == K_RD_ADR) || (kind_q == K_WR_ADR);
  assign gap_len = GW'(half) * GW'(2 * GAP_SPI);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; busy <= 1'b0; cyc_done <= 1'b0; cs_n <= 1'b1;
      sh_start <= 1'b0; sh_tx <= '0; buf_idx <= '0; buf_we <= 1'b0;
      buf_widx <= '0; buf_wdata <= '0; op_q <= '0; kind_q <= K_RD;
      de_q <= 1'b0; last_q <= '0; addr_q <= '0; abyte <= '0; gap_cnt <= '0;
    end else begin
      sh_start <= 1'b0; cyc_done <= 1'b0; buf_we <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          op_q <= opcode; kind_q <= kind; de_q <= data_en; last_q <= last;
          addr_q <= addr; busy <= 1'b1; cs_n <= 1'b0; sh_start <= 1'b1;
          sh_tx <= atomic ? prefix : opcode;
          st <= atomic ? S_PRE : S_CMD;
        end
        S_PRE: if (sh_done) begin
          cs_n <= 1'b1; gap_cnt <= '0; st <= S_GAP;
        end
        S_GAP: begin
          gap_cnt <= gap_cnt + 1'b1;
          if (gap_cnt == gap_len - 1'b1) begin
            cs_n <= 1'b0; sh_start <= 1'b1; sh_tx <= op_q; st <= S_CMD;
          end
        end
        S_CMD: if (sh_done) begin
          if (has_addr) begin
            sh_start <= 1'b1; sh_tx <= addr_q[23:16]; abyte <= '0; st <= S_ADDR;
          end else if (de_q) begin
            buf_idx <= '0; st <= S_DLOAD;
          end else begin
            cs_n <= 1'b1; busy <= 1'b0; cyc_done <= 1'b1; st <= S_IDLE;
          end
        end
        S_ADDR: if (sh_done) begin
          if (abyte == 2'd2) begin
            if (de_q) begin
              buf_idx <= '0; st <= S_DLOAD;
            end else begin
              cs_n <= 1'b1; busy <= 1'b0; cyc_done <= 1'b1; st <= S_IDLE;
            end
          end else begin
            abyte <= abyte + 2'd1; addr_q <= {addr_q[15:0], 8'h00};
            sh_start <= 1'b1; sh_tx <= addr_q[15:8];
          end
        end
        S_DLOAD: begin
          sh_start <= 1'b1; sh_tx <= is_write ? buf_rd : 8'h00; st <= S_DATA;
        end
        S_DATA: if (sh_done) begin
          if (!is_write) begin
            buf_we <= 1'b1; buf_widx <= buf_idx; buf_wdata <= sh_rx;
          end
          if (buf_idx == last_q) begin
            cs_n <= 1'b1; busy <= 1'b0; cyc_done <= 1'b1; st <= S_IDLE;
          end else begin
            buf_idx <= buf_idx + 1'b1; st <= S_DLOAD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_FRAME_CLOSED_AT_END: assert property (@(posedge clk) disable iff (rst) cyc_done |-> cs_n); // R6
endmodule

// File: rtl/spi_cycle_engine.sv
module spi_cycle_engine
  import spi_eng_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int DIV_SLOW  = 4,
  parameter int DIV_FAST  = 2,
  parameter int GAP_SPI   = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_we,
  input  logic [$clog2(BUF_BYTES/4):0] host_waddr,
  input  logic [31:0] host_wdata,
  input  logic [$clog2(BUF_BYTES/4):0] host_raddr,
  output logic [31:0] host_rdata,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int WORDS = BUF_BYTES / 4;
  localparam int WI_W  = $clog2(WORDS);
  localparam int HA_W  = WI_W + 1;
  localparam int CW    = $clog2(BUF_BYTES);
  localparam int DIV_W = $clog2((DIV_SLOW > DIV_FAST ? DIV_SLOW : DIV_FAST) + 1) + 1;

  logic [7:0]          dbuf [BUF_BYTES];
  logic [MENU_N*8-1:0] menu_q;
  logic [2*MENU_N-1:0] types_q;
  logic [7:0]          prefix_q;
  logic [23:0]         addr_q;
  logic [15:0]         ctrl_q;
  logic                locked, fast_q, pend_err, st_done, st_err;

  logic seq_busy, cyc_done, sh_start, sh_done, sh_busy, buf_we;
  logic [7:0] sh_tx, sh_rx, buf_wdata;
  logic [CW-1:0] buf_idx, buf_widx;
  logic [DIV_W-1:0] half;

  wire  reg_we  = host_we && !host_waddr[HA_W-1];
  reg_e wsel;
  assign wsel = reg_e'(host_waddr[2:0]);
  wire  go_wr   = reg_we && (wsel == RG_CTRL) && host_wdata[CTL_GO];
  wire  accept  = go_wr && !seq_busy;
  wire  [2:0] sel_idx = host_wdata[CTL_IDX +: 3];
  assign half = fast_q ? DIV_W'(DIV_FAST) : DIV_W'(DIV_SLOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      menu_q <= '0; types_q <= '0; prefix_q <= '0; addr_q <= '0; ctrl_q <= '0;
      locked <= 1'b0; fast_q <= 1'b0; pend_err <= 1'b0; st_done <= 1'b0; st_err <= 1'b0;
    end else begin
      if (reg_we) begin
        case (wsel)
          RG_CTRL:    ctrl_q <= host_wdata[15:0] & 16'hFFFE;
          RG_ADDR:    addr_q <= host_wdata[23:0];
          RG_TYPES:   if (!locked) types_q <= host_wdata[2*MENU_N-1:0];
          RG_PREFIX:  if (!locked) prefix_q <= host_wdata[7:0];
          RG_MENU_LO: if (!locked) menu_q[31:0] <= host_wdata;
          RG_MENU_HI: if (!locked) menu_q[63:32] <= host_wdata;
          RG_LOCK:    if (host_wdata[0]) locked <= 1'b1;
          default: ;
        endcase
      end
      if (accept) fast_q <= host_wdata[CTL_FAST];
      pend_err <= cyc_done ? 1'b0 : (pend_err | (go_wr & seq_busy));
      if (cyc_done) st_done <= 1'b1;
      else if (reg_we && wsel == RG_STAT && host_wdata[ST_DONE]) st_done <= 1'b0;
      if (cyc_done && pend_err) st_err <= 1'b1;
      else if (reg_we && wsel == RG_STAT && host_wdata[ST_ERR]) st_err <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < BUF_BYTES; b++) begin
      if (buf_we && buf_widx == CW'(b))
        dbuf[b] <= buf_wdata;
      else if (host_we && host_waddr[HA_W-1] && host_waddr[WI_W-1:0] == WI_W'(b / 4))
        dbuf[b] <= host_wdata[8*(b%4) +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else if (host_raddr[HA_W-1]) begin
      for (int k = 0; k < 4; k++)
        host_rdata[8*k +: 8] <= dbuf[{host_raddr[WI_W-1:0], 2'(k)}];
    end else begin
      case (reg_e'(host_raddr[2:0]))
        RG_CTRL:    host_rdata <= {16'h0, ctrl_q};
        RG_STAT:    host_rdata <= {29'h0, st_err, st_done, seq_busy};
        RG_ADDR:    host_rdata <= {8'h0, addr_q};
        RG_TYPES:   host_rdata <= {16'h0, types_q};
        RG_PREFIX:  host_rdata <= {24'h0, prefix_q};
        RG_MENU_LO: host_rdata <= menu_q[31:0];
        RG_MENU_HI: host_rdata <= menu_q[63:32];
        default:    host_rdata <= {31'h0, locked};
      endcase
    end
  end

  spi_cycle_seq #(.BUF_BYTES(BUF_BYTES), .GAP_SPI(GAP_SPI), .DIV_W(DIV_W)) i_seq (
    .clk(clk), .rst(rst), .start(accept),
    .opcode(menu_q[8*sel_idx +: 8]), .kind(kind_e'(types_q[2*sel_idx +: 2])),
    .atomic(host_wdata[CTL_ATOMIC]), .data_en(host_wdata[CTL_DATA]),
    .last(host_wdata[CTL_CNT +: CW]), .addr(addr_q), .prefix(prefix_q), .half(half),
    .buf_rd(dbuf[buf_idx]), .sh_done(sh_done), .sh_rx(sh_rx),
    .busy(seq_busy), .cyc_done(cyc_done), .cs_n(spi_cs_n), .sh_start(sh_start),
    .sh_tx(sh_tx), .buf_idx(buf_idx), .buf_we(buf_we), .buf_widx(buf_widx),
    .buf_wdata(buf_wdata)
  );

  spi_byte_shifter #(.DIV_W(DIV_W)) i_shift (
    .clk(clk), .rst(rst), .start(sh_start), .tx(sh_tx), .half(half), .miso(spi_miso),
    .busy(sh_busy), .done(sh_done), .rx(sh_rx), .sclk(spi_sclk), .mosi(spi_mosi)
  );

  AST_SHIFT_INSIDE_FRAME: assert property (@(posedge clk) disable iff (rst) sh_busy |-> !spi_cs_n); // R6
  AST_CLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (rst) spi_cs_n |-> !spi_sclk); // R2
  AST_DONE_AFTER_CYCLE:   assert property (@(posedge clk) disable iff (rst) $fell(seq_busy) |=> st_done); // R7
  AST_LOCK_STICKY:        assert property (@(posedge clk) disable iff (rst) locked |=> locked); // R10
  AST_LOCK_FREEZES:       assert property (@(posedge clk) disable iff (rst)
                            locked |=> ($stable(menu_q) && $stable(types_q) && $stable(prefix_q))); // R10
endmodule

// File: tb/test_spi_cycle_engine.sv
module test_spi_cycle_engine;
  localparam int DIV_SLOW = 4;
  localparam int DIV_FAST = 2;
  localparam int TCLK = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_we = 1'b0;
  logic [4:0] host_waddr = '0, host_raddr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  always #2 clk = ~clk;

  spi_cycle_engine i_spi_cycle_engine (
    .clk(clk), .rst(rst), .host_we(host_we), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0, fails = 0;
  int    exp_q[$];
  string tag_q[$];
  logic [7:0] resp [0:79];
  bit   armed = 0;
  int   nb = 0, pos = 0, bpos = 0;
  logic [7:0] shb = '0;
  logic p_sclk = 1'b0, p_cs = 1'b1;
  time  t_hi = 0, t_rise = 0, period = 0, last_gap = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic push(string tag, int v);
    exp_q.push_back(v); tag_q.push_back(tag);
  endtask

  task automatic take(int v);
    if (exp_q.size() == 0) chk("R3 unexpected wire item", 32'(v), 32'hFFFF);
    else begin
      int e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      chk(t, 32'(v), 32'(e));
    end
  endtask

  // Scoreboard monitor: decodes the SPI pins and pops expected items.
  always @(spi_sclk or spi_cs_n) begin
    if (spi_cs_n !== p_cs) begin
      if (spi_cs_n === 1'b0) begin
        nb = 0; pos = 0; bpos = 0;
        if (armed) last_gap = $time - t_hi;
      end else if (spi_cs_n === 1'b1) begin
        t_hi = $time;
        if (armed) take(256);
      end
    end
    if (spi_sclk !== p_sclk && spi_cs_n === 1'b0) begin
      if (spi_sclk) begin
        if (nb != 0) period = $time - t_rise;
        t_rise = $time;
        shb = {shb[6:0], spi_mosi};
        nb++;
        if (nb == 8) begin nb = 0; take(int'(shb)); end
      end else begin
        bpos++;
        if (bpos == 8) begin bpos = 0; pos++; end
      end
    end
    p_cs = spi_cs_n; p_sclk = spi_sclk;
    spi_miso = resp[pos][7-bpos];
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); host_we = 1'b1; host_waddr = 5'(a); host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); host_raddr = 5'(a);
    @(negedge clk); d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int g = 0;
    do begin rd(1, v); g++; end while (v[0] && g < 5000);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(bit at, bit de, int idx, int n, bit fast);
    return 32'(1 + (at ? 2 : 0) + (de ? 4 : 0) + (idx << 4) + ((n > 0 ? n - 1 : 0) << 8) + (fast ? 32'h8000 : 0));
  endfunction

  initial begin
    logic [31:0] v, types_w;
    logic [7:0] menu [8];
    int kinds [8];
    bit seen;
    menu = '{8'h03, 8'h02, 8'h06, 8'h05, 8'h9F, 8'h0B, 8'h20, 8'hC7};
    kinds = '{2, 3, 1, 0, 0, 2, 3, 1};
    types_w = 0;
    for (int i = 0; i < 8; i++) types_w |= 32'(kinds[i]) << (2 * i);
    for (int i = 0; i < 80; i++) resp[i] = 8'hEE;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    armed = 1;
    rd(1, v);
    chk("R1 status after reset", v, 0);
    chk("R1 cs_n after reset", 32'(spi_cs_n), 1);
    chk("R1 sclk after reset", 32'(spi_sclk), 0);

    wr(5, {menu[3], menu[2], menu[1], menu[0]});
    wr(6, {menu[7], menu[6], menu[5], menu[4]});
    wr(3, types_w);
    for (int w = 0; w < 16; w++) wr(16 + w, 32'h5566_7700 | 32'(w));

    // Read with address, slow clock, upper address bits ignored
    wr(2, 32'hAB12_3456);
    resp[4] = 8'hA1; resp[5] = 8'hB2; resp[6] = 8'hC3; resp[7] = 8'hD4;
    push("R3 opcode entry 0", 8'h03);
    push("R4 addr hi", 8'h12); push("R4 addr mid", 8'h34); push("R4 addr lo", 8'h56);
    for (int i = 0; i < 4; i++) push("R5 read filler", 0);
    push("R4 frame end", 256);
    wr(0, mk(0, 1, 0, 4, 0));
    wait_idle();
    chk("R3 all items seen", 32'(exp_q.size()), 0);
    rd(16, v); chk("R5 read bytes stored from 0", v, 32'hD4C3_B2A1);
    rd(17, v); chk("R5 bytes past count kept", v, 32'h5566_7701);
    rd(1, v);  chk("R7 done set, not busy", v, 32'h2);
    chk("R9 slow sclk period", 32'(period), 32'(2 * DIV_SLOW * TCLK));
    wr(1, 32'h6);
    rd(1, v);  chk("R7 write-one clears", v, 0);

    // Write with address, atomic prefix
    wr(16, 32'h3322_1110);
    wr(4, 32'h06);
    wr(2, 32'h0000_ABCD);
    push("R6 prefix byte", 8'h06); push("R6 prefix frame end", 256);
    push("R3 opcode entry 1", 8'h02);
    push("R4 addr", 8'h00); push("R4 addr", 8'hAB); push("R4 addr", 8'hCD);
    push("R5 write byte0", 8'h10); push("R5 write byte1", 8'h11); push("R5 write byte2", 8'h22);
    push("R6 main frame end", 256);
    wr(0, mk(1, 1, 1, 3, 0));
    wait_idle();
    chk("R6 all items seen", 32'(exp_q.size()), 0);
    chk("R6 deselect gap >= 2 SPI clocks", 32'(last_gap >= time'(2 * 2 * DIV_SLOW * TCLK)), 1);
    wr(1, 32'h6);

    // Write without address, no data, fast clock
    push("R3 opcode entry 2", 8'h06); push("R3 frame end", 256);
    wr(0, mk(0, 0, 2, 1, 1));
    wait_idle();
    chk("R3 all items seen", 32'(exp_q.size()), 0);
    chk("R9 fast sclk period", 32'(period), 32'(2 * DIV_FAST * TCLK));
    wr(1, 32'h6);

    // Read without address, 3 bytes
    resp[1] = 8'h5A; resp[2] = 8'h6B; resp[3] = 8'h7C;
    push("R3 opcode entry 4", 8'h9F);
    for (int i = 0; i < 3; i++) push("R5 read filler", 0);
    push("R3 frame end", 256);
    wr(0, mk(0, 1, 4, 3, 0));
    wait_idle();
    rd(16, v); chk("R5 partial word keeps byte3", v, 32'h337C_6B5A);
    wr(1, 32'h6);

    // Go while busy
    push("R8 single frame", 8'h06); push("R8 frame end", 256);
    wr(0, mk(0, 0, 2, 1, 0));
    wr(0, mk(0, 1, 0, 4, 0));
    wait_idle();
    repeat (100) @(negedge clk);
    chk("R8 no second frame", 32'(exp_q.size()), 0);
    rd(1, v); chk("R8 error and done", v, 32'h6);
    wr(1, 32'h6);

    // Set and clear of done in the same clock
    push("R7 frame", 8'h06); push("R7 frame end", 256);
    wr(0, mk(0, 0, 2, 1, 0));
    @(negedge clk);
    host_raddr = 5'd1; host_we = 1'b1; host_waddr = 5'd1; host_wdata = 32'h6;
    seen = 0;
    for (int g = 0; g < 2000; g++) begin
      @(negedge clk);
      if (host_rdata[0]) seen = 1;
      else if (seen) break;
    end
    host_we = 1'b0;
    rd(1, v); chk("R7 set wins over same-cycle clear", v, 32'h2);
    wr(1, 32'h6);

    // Lock
    wr(7, 1);
    wr(5, 32'hFFFF_FFFF); wr(3, 32'h0); wr(4, 32'hAA); wr(2, 32'h0000_0777);
    rd(5, v); chk("R10 table frozen", v, {menu[3], menu[2], menu[1], menu[0]});
    rd(3, v); chk("R10 kind word frozen", v, types_w);
    rd(4, v); chk("R10 prefix frozen", v, 32'h06);
    rd(2, v); chk("R10 address still writable", v, 32'h777);
    rd(7, v); chk("R10 lock reads set", v, 1);
    push("R10 locked table in use", 8'h06); push("R10 frame end", 256);
    wr(0, mk(0, 0, 2, 1, 0));
    wait_idle();
    chk("R10 all items seen", 32'(exp_q.size()), 0);

    summary();
  end
endmodule